// File: doc/BRIEF.md
# Burst Column Offset Sequencer

This block turns one burst request into the sequence of column offsets that a memory device walks through during a read or write burst. A one-cycle start pulse captures five settings: the burst-length mode, the ordering type, the three low starting column bits, the read/write direction and the per-command chop select. From the next clock on, the block presents one beat per clock for eight clocks. Each beat carries a 3-bit column offset and two flags. One flag marks beats whose outputs are tri-stated. The other marks beats whose data is don't-care.

The burst length can be fixed at eight beats, fixed at a chopped four beats, or chosen per command. In the per-command mode, the active-low chop select decides the length. Reads follow the requested start position. Writes use less of it: a chopped write keeps only the nibble select bit, and a full write always runs 0 through 7. The block also raises a one-clock pulse on the beat where the internal write operation begins. That pulse comes two clocks earlier for a fixed chopped length than for a full-length burst. The reserved length code runs as a full-length burst and raises an error flag.

Top module: `burst_order_gen`

## Requirements
- R1: After a synchronous active-low reset, and while no burst is running, beat_valid, beat_last, beat_hiz, beat_dc, wr_begin and len_err are all 0.
- R2: A start pulse sampled at a clock edge makes beat_valid 1 for exactly the next 8 clock periods, with the beat index running 0 to 7. beat_last is 1 only on index 7, and beat_valid is 0 in the period after it.
- R3: A start pulse that arrives while a burst is running is ignored. The running burst keeps its offsets, flags and length.
- R4: For a full-length read with ordering type sequential (ilv_mode=0) and start s, beat i has offset {s[2]^i[2], (s[1:0]+i[1:0]) mod 4}. For example, s=5 gives 5,6,7,4,1,2,3,0.
- R5: For a full-length read with ordering type interleave (ilv_mode=1), beat i has offset s XOR i. For example, s=6 gives 6,7,4,5,2,3,0,1.
- R6: A chopped read has beat_hiz=1 on beats 4 to 7 and 0 on beats 0 to 3, and beat_dc stays 0. Its beats 0 to 3 follow the R4/R5 formula from the full 3-bit start. A read is chopped when len_mode=2'b10 (fixed), or when len_mode=2'b01 with chop_n=0.
- R7: A chopped write (wr_dir=1) ignores start bits 1:0. Its beats 0 to 3 are {s[2],i[1:0]} in either ordering type. It has beat_dc=1 on beats 4 to 7, and beat_hiz stays 0.
- R8: A full-length write ignores all three start bits and gives offsets 0,1,...,7 in either ordering type.
- R9: With len_mode=2'b01 and chop_n=1, the burst is full length. With len_mode 2'b00 or 2'b10, chop_n has no effect.
- R10: For a write, wr_begin pulses once. It fires on beat 5 when len_mode=2'b10 and on beat 7 otherwise, including a per-command chopped write. It never fires for a read.
- R11: len_mode=2'b11 is reserved. It behaves as a full-length burst, and len_err is 1 on all 8 beats of that burst and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle burst request |
| len_mode | input | 2 | 00 full, 01 per-command, 10 fixed chopped, 11 reserved |
| ilv_mode | input | 1 | 0 sequential, 1 interleave ordering |
| start_col | input | BEAT_W | Low starting column bits |
| wr_dir | input | 1 | 1 write, 0 read |
| chop_n | input | 1 | Per-command chop select, active low |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_ofs | output | BEAT_W | Column offset of the beat |
| beat_hiz | output | 1 | Beat outputs tri-stated (chopped read tail) |
| beat_dc | output | 1 | Beat data don't-care (chopped write tail) |
| beat_last | output | 1 | Final beat of the burst |
| wr_begin | output | 1 | Internal write operation begins |
| len_err | output | 1 | Burst was loaded with the reserved length code |

## Verification
The bench builds the block with its default parameters: 3 start bits, the full-length write start on beat 7, and a pull-in of 2 beats. At these values every start position and every chopped tail can be reached, and both write-start timings fall inside the 8-beat window. Seeded random bursts run across all length codes, ordering types, directions and chop selects. Directed cases cover the two worked orderings, the per-command full-length case, the reserved code and a start pulse that arrives mid-burst.

// File: rtl/burst_order_pkg.sv
// Shared types for the burst offset sequencer.
// Assumes a 2-bit length-mode code as listed in the brief.
package burst_order_pkg;

    typedef enum logic [1:0] {
        LEN_FULL  = 2'b00,
        LEN_OTF   = 2'b01,
        LEN_CHOP  = 2'b10,
        LEN_RSVD  = 2'b11
    } len_mode_e;

    // Decoded settings captured at burst start
    typedef struct packed {
        logic chop;        // burst is four beats long
        logic fixed_chop;  // chop comes from the fixed mode (write pull-in)
        logic ilv;         // interleave ordering
        logic wr;          // write direction
        logic rsvd;        // reserved length code was loaded
    } burst_cfg_t;

endpackage

// File: rtl/burst_cfg_latch.sv
// Decodes the request settings and holds them for the length of a burst.
// Assumes load is a single-cycle pulse and is only given while idle.
// The stored base is the effective start position after write masking.
module burst_cfg_latch
    import burst_order_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        len_mode,
    input  logic              ilv_mode,
    input  logic [BEAT_W-1:0] start_col,
    input  logic              wr_dir,
    input  logic              chop_n,
    output burst_cfg_t        cfg_q,
    output logic [BEAT_W-1:0] base_q
);

    burst_cfg_t        cfg_d;
    logic [BEAT_W-1:0] base_d;

    // Decode the length mode and mask the start bits a write does not use
    always_comb begin
        cfg_d.fixed_chop = (len_mode_e'(len_mode) == LEN_CHOP);
        cfg_d.chop       = cfg_d.fixed_chop ||
                           ((len_mode_e'(len_mode) == LEN_OTF) && !chop_n);
        cfg_d.ilv        = ilv_mode;
        cfg_d.wr         = wr_dir;
        cfg_d.rsvd       = (len_mode_e'(len_mode) == LEN_RSVD);
        if (!wr_dir)
            base_d = start_col;
        else if (cfg_d.chop)
            base_d = {start_col[BEAT_W-1], {(BEAT_W-1){1'b0}}};
        else
            base_d = '0;
    end

    // Capture the decoded settings on a burst start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            cfg_q  <= cfg_d;
            base_q <= base_d;
        end
    end

    // A write never keeps low start bits when chopped (R7)
    assert_wr_chop_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_dir && cfg_d.chop) |=> (base_q[BEAT_W-2:0] == '0));

endmodule

// File: rtl/burst_seq_ctr.sv
// Beat counter: runs one pass of 2**BEAT_W beats after an accepted start.
// Assumes a start pulse during a running burst must be dropped.
module burst_seq_ctr #(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              load,
    output logic              active,
    output logic [BEAT_W-1:0] idx,
    output logic              last
);

    // A start is accepted only when idle; the final beat is the all-ones index
    always_comb begin
        load = start && !active;
        last = active && (&idx);
    end

    // Advance the beat index and end the burst after its final beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (last)
                active <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

    // Beats follow one another without a gap (R2)
    assert_next_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (active && idx == $past(idx) + 1'b1));

    // A burst only begins after a start pulse, at index 0 (R2)
    assert_start_to_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(start) && idx == '0));

    // The final beat closes the burst (R2)
    assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !active);

endmodule

// File: rtl/burst_ofs_calc.sv
// Computes the beat offset, the tail flags, the write-start pulse and the
// reserved-code flag from the held settings and the current beat index.
// Assumes base already has the write masking applied.
module burst_ofs_calc
    import burst_order_pkg::*;
#(
    parameter int BEAT_W      = 3,
    parameter int WR_BL8_BEAT = 7,
    parameter int BC4_PULL_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [BEAT_W-1:0] idx,
    input  burst_cfg_t        cfg,
    input  logic [BEAT_W-1:0] base,
    output logic [BEAT_W-1:0] ofs,
    output logic              hiz,
    output logic              dc,
    output logic              wr_start,
    output logic              err
);

    localparam logic [BEAT_W-1:0] WR_FULL_IDX = BEAT_W'(WR_BL8_BEAT);
    localparam logic [BEAT_W-1:0] WR_CHOP_IDX = BEAT_W'(WR_BL8_BEAT - BC4_PULL_IN);

    logic [BEAT_W-1:0] ilv_ofs;
    logic [BEAT_W-1:0] seq_ofs;
    logic              tail;

    // Interleave: each bit of the start flipped by the matching index bit
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_ofs[b] = base[b] ^ idx[b];
    end

    // Sequential: count within the half, top bit selects the half
    always_comb begin
        seq_ofs[BEAT_W-2:0] = base[BEAT_W-2:0] + idx[BEAT_W-2:0];
        seq_ofs[BEAT_W-1]   = base[BEAT_W-1] ^ idx[BEAT_W-1];
    end

    // Pick the ordering and mark the chopped tail and write start
    always_comb begin
        ofs      = cfg.ilv ? ilv_ofs : seq_ofs;
        tail     = idx[BEAT_W-1];
        hiz      = active && cfg.chop && !cfg.wr && tail;
        dc       = active && cfg.chop && cfg.wr && tail;
        wr_start = active && cfg.wr &&
                   (idx == (cfg.fixed_chop ? WR_CHOP_IDX : WR_FULL_IDX));
        err      = active && cfg.rsvd;
    end

    // Tail flags are never both set (R6, R7)
    assert_tail_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hiz && dc));

    // Nothing is flagged outside a burst (R1)
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!hiz && !dc && !wr_start && !err));

    // The write start pulse is a single cycle (R10)
    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

endmodule

// File: rtl/burst_order_gen.sv
// Top: burst column offset sequencer. Ties the settings latch, the beat
// counter and the offset calculator together.
// Assumes inputs are synchronous to clk; start is a single-cycle pulse.
module burst_order_gen
    import burst_order_pkg::*;
#(
    parameter int BEAT_W      = 3,
    parameter int WR_BL8_BEAT = 7,
    parameter int BC4_PULL_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        len_mode,
    input  logic              ilv_mode,
    input  logic [BEAT_W-1:0] start_col,
    input  logic              wr_dir,
    input  logic              chop_n,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_ofs,
    output logic              beat_hiz,
    output logic              beat_dc,
    output logic              beat_last,
    output logic              wr_begin,
    output logic              len_err
);

    logic              load;
    logic              active;
    logic              last;
    logic [BEAT_W-1:0] idx;
    burst_cfg_t        cfg_q;
    logic [BEAT_W-1:0] base_q;

    burst_seq_ctr #(.BEAT_W(BEAT_W)) ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .active (active),
        .idx    (idx),
        .last   (last)
    );

    burst_cfg_latch #(.BEAT_W(BEAT_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .len_mode  (len_mode),
        .ilv_mode  (ilv_mode),
        .start_col (start_col),
        .wr_dir    (wr_dir),
        .chop_n    (chop_n),
        .cfg_q     (cfg_q),
        .base_q    (base_q)
    );

    burst_ofs_calc #(
        .BEAT_W      (BEAT_W),
        .WR_BL8_BEAT (WR_BL8_BEAT),
        .BC4_PULL_IN (BC4_PULL_IN)
    ) calc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .idx      (idx),
        .cfg      (cfg_q),
        .base     (base_q),
        .ofs      (beat_ofs),
        .hiz      (beat_hiz),
        .dc       (beat_dc),
        .wr_start (wr_begin),
        .err      (len_err)
    );

    // Drive the beat strobes from the counter
    always_comb begin
        beat_valid = active;
        beat_last  = last;
    end

    // Settings stay fixed through a running burst, even on a new start (R3)
    assert_cfg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> ($stable(cfg_q) && $stable(base_q)));

endmodule

// File: tb/burst_order_gen_tb.sv
// Bench for burst_order_gen: seeded random bursts plus directed cases,
// checked at the falling edge against model functions.
module burst_order_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] len_mode = 2'b00;
    logic       ilv_mode = 1'b0;
    logic [2:0] start_col = 3'd0;
    logic       wr_dir = 1'b0;
    logic       chop_n = 1'b1;
    logic       beat_valid, beat_hiz, beat_dc, beat_last, wr_begin, len_err;
    logic [2:0] beat_ofs;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    burst_order_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .len_mode(len_mode),
        .ilv_mode(ilv_mode), .start_col(start_col), .wr_dir(wr_dir),
        .chop_n(chop_n), .beat_valid(beat_valid), .beat_ofs(beat_ofs),
        .beat_hiz(beat_hiz), .beat_dc(beat_dc), .beat_last(beat_last),
        .wr_begin(wr_begin), .len_err(len_err)
    );

    function automatic bit is_chop(int m, bit bcn);
        return (m == 2) || (m == 1 && !bcn);
    endfunction

    function automatic logic [2:0] exp_ofs(int m, bit il, logic [2:0] col,
                                           bit wr, bit bcn, int i);
        logic [2:0] b;
        logic [2:0] iv;
        logic [1:0] lo;
        iv = 3'(i);
        if (!wr)                 b = col;
        else if (is_chop(m, bcn)) b = {col[2], 2'b00};
        else                     b = 3'd0;
        if (il) return b ^ iv;
        lo = b[1:0] + iv[1:0];
        return {b[2] ^ iv[2], lo};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Runs one burst; poke_at >= 0 sends a stray start on that beat
    task automatic run_burst(int m, bit il, logic [2:0] col, bit wr, bit bcn,
                             int poke_at, string otag);
        bit    ch;
        string ot;
        ch = is_chop(m, bcn);
        if (otag != "")  ot = otag;
        else if (wr)     ot = ch ? "R7" : "R8";
        else if (ch)     ot = "R6";
        else             ot = il ? "R5" : "R4";
        start = 1'b1; len_mode = 2'(m); ilv_mode = il; start_col = col;
        wr_dir = wr; chop_n = bcn;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (i == poke_at) begin
                start = 1'b1; len_mode = 2'b10; ilv_mode = ~il;
                start_col = ~col; wr_dir = ~wr; chop_n = ~bcn;
            end
            chk(beat_valid == 1'b1, "R2 valid", int'(beat_valid), 1);
            chk(beat_last == (i == 7), "R2 last", int'(beat_last), int'(i == 7));
            if (!(ch && i >= 4))
                chk(beat_ofs == exp_ofs(m, il, col, wr, bcn, i), ot,
                    int'(beat_ofs), int'(exp_ofs(m, il, col, wr, bcn, i)));
            chk(beat_hiz == (ch && !wr && i >= 4), "R6 hiz",
                int'(beat_hiz), int'(ch && !wr && i >= 4));
            chk(beat_dc == (ch && wr && i >= 4), "R7 dc",
                int'(beat_dc), int'(ch && wr && i >= 4));
            chk(wr_begin == (wr && i == ((m == 2) ? 5 : 7)), "R10 wr_begin",
                int'(wr_begin), int'(wr && i == ((m == 2) ? 5 : 7)));
            chk(len_err == (m == 3), "R11 len_err", int'(len_err), int'(m == 3));
        end
        @(negedge clk);
        start = 1'b0;
        chk(beat_valid == 1'b0, "R2 end", int'(beat_valid), 0);
        chk(len_err == 1'b0, "R11 idle", int'(len_err), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1d4c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!beat_valid && !beat_last && !beat_hiz && !beat_dc && !wr_begin && !len_err,
            "R1 reset", int'({beat_valid, beat_last, beat_hiz, beat_dc, wr_begin, len_err}), 0);

        // Directed worked orderings
        run_burst(0, 1'b0, 3'd5, 1'b0, 1'b1, -1, "R4");
        run_burst(0, 1'b1, 3'd6, 1'b0, 1'b1, -1, "R5");
        run_burst(2, 1'b0, 3'd3, 1'b0, 1'b1, -1, "R6");
        run_burst(1, 1'b1, 3'd5, 1'b0, 1'b0, -1, "R6");
        run_burst(2, 1'b0, 3'd7, 1'b1, 1'b1, -1, "R7");
        run_burst(1, 1'b1, 3'd6, 1'b1, 1'b0, -1, "R10");
        run_burst(0, 1'b1, 3'd5, 1'b1, 1'b1, -1, "R8");
        // R9: per-command with chop_n high is full length; chop_n ignored in fixed modes
        run_burst(1, 1'b0, 3'd2, 1'b0, 1'b1, -1, "R9");
        run_burst(0, 1'b0, 3'd2, 1'b0, 1'b0, -1, "R9");
        run_burst(2, 1'b1, 3'd1, 1'b0, 1'b1, -1, "R9");
        // R11: reserved code runs as full length
        run_burst(3, 1'b0, 3'd5, 1'b0, 1'b1, -1, "R11");
        run_burst(3, 1'b0, 3'd5, 1'b1, 1'b0, -1, "R11");
        // R3: stray start mid-burst is ignored
        run_burst(0, 1'b0, 3'd1, 1'b0, 1'b1, 3, "R3");
        run_burst(2, 1'b1, 3'd4, 1'b1, 1'b1, 6, "R3");

        // Seeded random bursts
        for (int n = 0; n < 300; n++) begin
            run_burst(int'($urandom_range(0, 3)), 1'($urandom), 3'($urandom),
                      1'($urandom), 1'($urandom), -1, "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule